// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the home node for a small group of memory blocks shared by several processing elements (PEs). For each block it records which PEs hold a copy, as a presence vector with one bit per PE, and whether a single PE owns the block in a modified state, as a dirty flag. Requests arrive from the PEs on one valid/ready channel. The controller resolves each request against the directory entry and then sends targeted messages over a probe channel. Each message goes only to a PE whose presence bit is set. A PE that owns the block is asked to give up its data and keep a shared copy. A PE that must lose its copy is invalidated. A PE that is both owner and loser is asked to give up its data and drop the line.

Each probe is answered on an acknowledge channel. Data carried by an acknowledge is written into the backing store, which is an internal register array. After every outstanding acknowledge has arrived, the controller updates the directory entry and sends one response to the requester. A read is answered with data. A write is answered with a grant that carries the current data. A PE that evicts a modified line returns it with a write-back request. Only one read or write transaction is in progress at a time. While it runs, its block is marked busy. A request to the busy block is answered with a retry at once, and a request to any other block is held back.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid`, `prb_valid` and `ack_ready` are low, no PE is recorded for any block, no block is dirty, and block b holds the value b*17 truncated to DATA_W bits.
- R2: A read (req_op 0) of a block that is not dirty sends no probe. It returns a response of kind 0 (data) carrying the stored value and adds the requester to the presence vector.
- R3: A read of a dirty block sends one probe of kind 0 (recall, keep shared) to the owner only. The data in the owner's acknowledge is written to memory and returned to the requester in a kind 0 response. The dirty flag is cleared, and the owner and the requester are both recorded.
- R4: A write (req_op 1) to a block that is not dirty sends a probe of kind 1 (invalidate) to each recorded PE other than the requester, one per cycle, lowest PE index first. The grant response (kind 1) is sent only after every one of those PEs has acknowledged. Afterwards only the requester is recorded and the block is dirty.
- R5: No probe is ever sent to the requester or to a PE whose presence bit is clear.
- R6: A write to a block owned dirty by another PE sends a probe of kind 2 (recall and invalidate) to the owner. The acknowledged data is written to memory and returned in the grant, and ownership passes to the requester alone.
- R7: While a read or write transaction is in progress on block B, a request for B gets a response of kind 2 (retry) and leaves B's directory entry unchanged. Requests for any other block see `req_ready` low.
- R8: A write-back (req_op 2) from the dirty owner stores `req_data`, clears that PE's presence bit and the dirty flag, and gets a response of kind 3. A write-back from any other PE gets the same kind 3 response and changes nothing.
- R9: While `rsp_valid` or `prb_valid` is high and its ready is low, that channel's valid and payload stay unchanged.
- R10: Whenever a block is dirty, exactly one presence bit is set for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_pe | input | PE_W | Requesting PE index |
| req_op | input | 2 | 0 read, 1 write, 2 write-back |
| req_blk | input | BLK_W | Block index |
| req_data | input | DATA_W | Write-back data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_pe | output | PE_W | Destination PE |
| rsp_kind | output | 2 | 0 data, 1 grant, 2 retry, 3 write-back done |
| rsp_data | output | DATA_W | Block data for kinds 0 and 1 |
| prb_valid | output | 1 | Probe present |
| prb_ready | input | 1 | Probe taken |
| prb_pe | output | PE_W | Probed PE |
| prb_kind | output | 2 | 0 recall keep shared, 1 invalidate, 2 recall and invalidate |
| prb_blk | output | BLK_W | Probed block |
| ack_valid | input | 1 | Probe acknowledge present |
| ack_ready | output | 1 | Acknowledges accepted |
| ack_pe | input | PE_W | Acknowledging PE |
| ack_data | input | DATA_W | Line data returned by a recall |

## Verification
While a write is waiting on an invalidate, the probe channel is stalled. In that state a read from another PE is sent to the same block, so that the retry response and the pending probe are both valid in the same cycle. Both channels are then held unready for a cycle to confirm that neither payload moves. After the retry drains and the acknowledge arrives, the grant must still reach the writer. A later write-back and a write by a third PE must show that the retried reader was never recorded as a sharer.

// File: rtl/coh_dir_pkg.sv
// Shared encodings for the coherence directory controller.
// Assumes request, probe and response codes fit in two bits.
package coh_dir_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WBACK = 2'd2,
        OP_RSVD  = 2'd3
    } req_op_e;

    typedef enum logic [1:0] {
        PRB_SHARE = 2'd0,
        PRB_INV   = 2'd1,
        PRB_RINV  = 2'd2,
        PRB_RSVD  = 2'd3
    } prb_kind_e;

    typedef enum logic [1:0] {
        RSP_DATA   = 2'd0,
        RSP_GRANT  = 2'd1,
        RSP_RETRY  = 2'd2,
        RSP_WBDONE = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_RESP = 2'd2
    } dir_state_e;

endpackage

// File: rtl/coh_dir_pick.sv
// Lowest-index picker: finds the lowest set bit of a vector.
// Assumes N >= 2. Purely combinational.
module coh_dir_pick #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);

    logic [N-1:0] lower;
    logic [N-1:0] first;

    assign lower[0] = 1'b0;

    // prefix chain: lower[k] is high when some bit below k is set
    for (genvar k = 1; k < N; k++) begin : g_chain
        assign lower[k] = lower[k-1] | vec[k-1];
    end

    assign first = vec & ~lower;
    assign any   = |vec;

    // encode the single surviving bit into an index
    always_comb begin
        idx = '0;
        for (int k = 0; k < N; k++) begin
            if (first[k]) idx = idx | IW'(k);
        end
    end

endmodule

// File: rtl/coh_dir_table.sv
// Directory and backing store: per block a presence vector, a dirty
// flag, a busy flag and one data word. Two read ports (request side
// and transaction side), one directory write port, one memory write
// port, and separate set/clear ports for busy. Assumes NUM_BLK is a
// power of two so every index selects a block.
module coh_dir_table #(
    parameter  int NUM_PE  = 4,
    parameter  int NUM_BLK = 8,
    parameter  int DATA_W  = 16,
    localparam int BLK_W   = $clog2(NUM_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BLK_W-1:0]  rd_a_blk,
    output logic [NUM_PE-1:0] rd_a_pres,
    output logic              rd_a_dirty,
    output logic              rd_a_busy,
    input  logic [BLK_W-1:0]  rd_b_blk,
    output logic [NUM_PE-1:0] rd_b_pres,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              dir_we,
    input  logic [BLK_W-1:0]  dir_blk,
    input  logic [NUM_PE-1:0] dir_pres,
    input  logic              dir_dirty,
    input  logic              busy_set,
    input  logic [BLK_W-1:0]  busy_set_blk,
    input  logic              busy_clr,
    input  logic [BLK_W-1:0]  busy_clr_blk,
    input  logic              mem_we,
    input  logic [BLK_W-1:0]  mem_blk,
    input  logic [DATA_W-1:0] mem_wdata
);

    logic [NUM_PE-1:0] pres_all  [NUM_BLK];
    logic              dirty_all [NUM_BLK];
    logic              busy_all  [NUM_BLK];
    logic [DATA_W-1:0] data_all  [NUM_BLK];

    for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
        localparam logic [DATA_W-1:0] INIT = DATA_W'(b * 17);
        logic [NUM_PE-1:0] pres_q;
        logic              dirty_q;
        logic              busy_q;
        logic [DATA_W-1:0] data_q;

        // directory entry update
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pres_q  <= '0;
                dirty_q <= 1'b0;
            end else if (dir_we && dir_blk == BLK_W'(b)) begin
                pres_q  <= dir_pres;
                dirty_q <= dir_dirty;
            end
        end

        // busy flag: set on transaction start, cleared on its response
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q <= 1'b0;
            end else if (busy_set && busy_set_blk == BLK_W'(b)) begin
                busy_q <= 1'b1;
            end else if (busy_clr && busy_clr_blk == BLK_W'(b)) begin
                busy_q <= 1'b0;
            end
        end

        // backing store word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= INIT;
            end else if (mem_we && mem_blk == BLK_W'(b)) begin
                data_q <= mem_wdata;
            end
        end

        assign pres_all[b]  = pres_q;
        assign dirty_all[b] = dirty_q;
        assign busy_all[b]  = busy_q;
        assign data_all[b]  = data_q;
    end

    assign rd_a_pres  = pres_all[rd_a_blk];
    assign rd_a_dirty = dirty_all[rd_a_blk];
    assign rd_a_busy  = busy_all[rd_a_blk];
    assign rd_b_pres  = pres_all[rd_b_blk];
    assign rd_b_data  = data_all[rd_b_blk];

endmodule

// File: rtl/coh_dir_ctrl.sv
// Home-node directory controller. Accepts read, write and write-back
// requests, runs one read/write transaction at a time, sends probes only
// to recorded PEs (lowest index first), collects acknowledges, then
// updates the directory and responds. Requests to the busy block are
// answered with retry; others wait. Write-backs are handled in one step
// while idle. Assumes NUM_PE >= 2 and acknowledges come only from probed PEs.
module coh_dir_ctrl
    import coh_dir_pkg::*;
#(
    parameter  int NUM_PE  = 4,
    parameter  int NUM_BLK = 8,
    parameter  int DATA_W  = 16,
    localparam int PE_W    = $clog2(NUM_PE),
    localparam int BLK_W   = $clog2(NUM_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PE_W-1:0]   req_pe,
    input  logic [1:0]        req_op,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PE_W-1:0]   rsp_pe,
    output logic [1:0]        rsp_kind,
    output logic [DATA_W-1:0] rsp_data,
    output logic              prb_valid,
    input  logic              prb_ready,
    output logic [PE_W-1:0]   prb_pe,
    output logic [1:0]        prb_kind,
    output logic [BLK_W-1:0]  prb_blk,
    input  logic              ack_valid,
    output logic              ack_ready,
    input  logic [PE_W-1:0]   ack_pe,
    input  logic [DATA_W-1:0] ack_data
);

    // transaction state
    dir_state_e        state_q;
    req_op_e           t_op;
    prb_kind_e         t_kind;
    logic [PE_W-1:0]   t_pe;
    logic [BLK_W-1:0]  t_blk;
    logic [NUM_PE-1:0] tgt_q;
    logic [NUM_PE-1:0] wait_q;

    // response register
    logic              rsp_valid_q;
    logic [PE_W-1:0]   rsp_pe_q;
    rsp_kind_e         rsp_kind_q;
    logic [DATA_W-1:0] rsp_data_q;

    // table read side
    logic [NUM_PE-1:0] a_pres;
    logic              a_dirty;
    logic              a_busy;
    logic [NUM_PE-1:0] b_pres;
    logic [DATA_W-1:0] b_data;

    // table write side
    logic              dir_we;
    logic [BLK_W-1:0]  dir_blk;
    logic [NUM_PE-1:0] dir_pres;
    logic              dir_dirty;
    logic              mem_we;
    logic [BLK_W-1:0]  mem_blk;
    logic [DATA_W-1:0] mem_wdata;
    logic              busy_clr;

    // decode and control
    req_op_e           op_in;
    logic              in_xfer;
    logic              xfer_done;
    logic              req_fire;
    logic              retry_fire;
    logic              start_fire;
    logic              wb_fire;
    logic              wb_owner;
    logic [NUM_PE-1:0] req_bit;
    logic [NUM_PE-1:0] others;
    logic [NUM_PE-1:0] t_bit;
    logic [NUM_PE-1:0] start_tgt;
    prb_kind_e         start_kind;
    logic              pick_any;
    logic [PE_W-1:0]   pick_idx;
    logic              prb_fire;
    logic [NUM_PE-1:0] sent_bit;
    logic              ack_fire;
    logic              ack_hit;
    logic [NUM_PE-1:0] ack_bit;

    coh_dir_table #(
        .NUM_PE (NUM_PE),
        .NUM_BLK(NUM_BLK),
        .DATA_W (DATA_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_a_blk    (req_blk),
        .rd_a_pres   (a_pres),
        .rd_a_dirty  (a_dirty),
        .rd_a_busy   (a_busy),
        .rd_b_blk    (t_blk),
        .rd_b_pres   (b_pres),
        .rd_b_data   (b_data),
        .dir_we      (dir_we),
        .dir_blk     (dir_blk),
        .dir_pres    (dir_pres),
        .dir_dirty   (dir_dirty),
        .busy_set    (start_fire),
        .busy_set_blk(req_blk),
        .busy_clr    (busy_clr),
        .busy_clr_blk(t_blk),
        .mem_we      (mem_we),
        .mem_blk     (mem_blk),
        .mem_wdata   (mem_wdata)
    );

    coh_dir_pick #(
        .N(NUM_PE)
    ) u_pick (
        .vec(tgt_q),
        .any(pick_any),
        .idx(pick_idx)
    );

    assign op_in     = req_op_e'(req_op);
    assign in_xfer   = (state_q == ST_XFER);
    assign xfer_done = in_xfer && (tgt_q == '0) && (wait_q == '0) && !rsp_valid_q;

    assign req_ready  = !rsp_valid_q && ((state_q == ST_IDLE) || (a_busy && !xfer_done));
    assign req_fire   = req_valid && req_ready;
    assign retry_fire = req_fire && (state_q != ST_IDLE);
    assign start_fire = req_fire && (state_q == ST_IDLE) && (op_in != OP_WBACK);
    assign wb_fire    = req_fire && (state_q == ST_IDLE) && (op_in == OP_WBACK);

    assign req_bit  = NUM_PE'(1) << req_pe;
    assign others   = a_pres & ~req_bit;
    assign t_bit    = NUM_PE'(1) << t_pe;
    assign wb_owner = a_dirty && |(a_pres & req_bit);

    // probe plan for a new transaction from the directory entry
    always_comb begin
        if (op_in == OP_WRITE) begin
            start_tgt  = others;
            start_kind = a_dirty ? PRB_RINV : PRB_INV;
        end else begin
            start_tgt  = a_dirty ? others : '0;
            start_kind = PRB_SHARE;
        end
    end

    // probe and acknowledge channels
    assign prb_valid = in_xfer && pick_any;
    assign prb_pe    = pick_idx;
    assign prb_kind  = t_kind;
    assign prb_blk   = t_blk;
    assign prb_fire  = prb_valid && prb_ready;
    assign sent_bit  = prb_fire ? (NUM_PE'(1) << pick_idx) : '0;

    assign ack_ready = in_xfer;
    assign ack_fire  = ack_valid && ack_ready;
    assign ack_bit   = NUM_PE'(1) << ack_pe;
    assign ack_hit   = ack_fire && |((wait_q | sent_bit) & ack_bit);

    // directory and memory write selection
    always_comb begin
        dir_we    = xfer_done || (wb_fire && wb_owner);
        dir_blk   = in_xfer ? t_blk : req_blk;
        dir_pres  = others;
        dir_dirty = 1'b0;
        if (in_xfer) begin
            dir_pres  = (t_op == OP_WRITE) ? t_bit : (b_pres | t_bit);
            dir_dirty = (t_op == OP_WRITE);
        end
        mem_we    = (ack_hit && t_kind != PRB_INV) || (wb_fire && wb_owner);
        mem_blk   = in_xfer ? t_blk : req_blk;
        mem_wdata = in_xfer ? ack_data : req_data;
    end

    assign busy_clr = (state_q == ST_RESP) && rsp_valid_q && rsp_ready;

    // transaction sequencing and probe/ack bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            t_op    <= OP_READ;
            t_kind  <= PRB_SHARE;
            t_pe    <= '0;
            t_blk   <= '0;
            tgt_q   <= '0;
            wait_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_fire) begin
                        t_op    <= op_in;
                        t_kind  <= start_kind;
                        t_pe    <= req_pe;
                        t_blk   <= req_blk;
                        tgt_q   <= start_tgt;
                        wait_q  <= '0;
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    tgt_q  <= tgt_q & ~sent_bit;
                    wait_q <= (wait_q | sent_bit) & ~(ack_hit ? ack_bit : '0);
                    if (xfer_done) state_q <= ST_RESP;
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // response register: loaded by completion, retry or write-back
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_pe_q    <= '0;
            rsp_kind_q  <= RSP_DATA;
            rsp_data_q  <= '0;
        end else if (xfer_done) begin
            rsp_valid_q <= 1'b1;
            rsp_pe_q    <= t_pe;
            rsp_kind_q  <= (t_op == OP_WRITE) ? RSP_GRANT : RSP_DATA;
            rsp_data_q  <= b_data;
        end else if (retry_fire) begin
            rsp_valid_q <= 1'b1;
            rsp_pe_q    <= req_pe;
            rsp_kind_q  <= RSP_RETRY;
            rsp_data_q  <= '0;
        end else if (wb_fire) begin
            rsp_valid_q <= 1'b1;
            rsp_pe_q    <= req_pe;
            rsp_kind_q  <= RSP_WBDONE;
            rsp_data_q  <= '0;
        end else if (rsp_valid_q && rsp_ready) begin
            rsp_valid_q <= 1'b0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_pe    = rsp_pe_q;
    assign rsp_kind  = rsp_kind_q;
    assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/coh_dir_ctrl_chk.sv
// Property checker for coh_dir_ctrl, attached by bind. Observes ports
// and a few internal signals; drives nothing.
module coh_dir_ctrl_chk #(
    parameter  int NUM_PE  = 4,
    parameter  int NUM_BLK = 8,
    parameter  int DATA_W  = 16,
    localparam int PE_W    = $clog2(NUM_PE),
    localparam int BLK_W   = $clog2(NUM_BLK)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [PE_W-1:0]   rsp_pe,
    input logic [1:0]        rsp_kind,
    input logic [DATA_W-1:0] rsp_data,
    input logic              prb_valid,
    input logic              prb_ready,
    input logic [PE_W-1:0]   prb_pe,
    input logic [1:0]        prb_kind,
    input logic [BLK_W-1:0]  prb_blk,
    input logic [PE_W-1:0]   t_pe,
    input logic [NUM_PE-1:0] tgt_q,
    input logic [NUM_PE-1:0] wait_q,
    input logic [NUM_PE-1:0] a_pres,
    input logic              a_dirty,
    input logic              in_xfer
);

    p_rsp_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pe)
            && $stable(rsp_kind) && $stable(rsp_data));

    p_prb_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid && !prb_ready |=> prb_valid && $stable(prb_pe)
            && $stable(prb_kind) && $stable(prb_blk));

    p_no_self_probe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid |-> prb_pe != t_pe);

    p_grant_after_acks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_kind == 2'd1 |-> tgt_q == '0 && wait_q == '0);

    p_dirty_one_owner_r10: assert property (@(posedge clk) disable iff (!rst_n)
        a_dirty |-> $countones(a_pres) == 1);

    p_retry_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) && rsp_kind == 2'd2 |-> $past(in_xfer));

endmodule

bind coh_dir_ctrl coh_dir_ctrl_chk #(
    .NUM_PE (NUM_PE),
    .NUM_BLK(NUM_BLK),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_pe   (rsp_pe),
    .rsp_kind (rsp_kind),
    .rsp_data (rsp_data),
    .prb_valid(prb_valid),
    .prb_ready(prb_ready),
    .prb_pe   (prb_pe),
    .prb_kind (prb_kind),
    .prb_blk  (prb_blk),
    .t_pe     (t_pe),
    .tgt_q    (tgt_q),
    .wait_q   (wait_q),
    .a_pres   (a_pres),
    .a_dirty  (a_dirty),
    .in_xfer  (in_xfer)
);

// File: tb/coh_dir_ctrl_tb.sv
`timescale 1ns/1ps
// Bench for coh_dir_ctrl: a vector table walked by one loop, followed
// by directed tests for reset, retry/stall overlap and write-back effects.
module coh_dir_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_pe = '0;
    logic [1:0]  req_op = '0;
    logic [2:0]  req_blk = '0;
    logic [15:0] req_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b1;
    logic [1:0]  rsp_pe;
    logic [1:0]  rsp_kind;
    logic [15:0] rsp_data;
    logic        prb_valid;
    logic        prb_ready = 1'b1;
    logic [1:0]  prb_pe;
    logic [1:0]  prb_kind;
    logic [2:0]  prb_blk;
    logic        ack_valid = 1'b0;
    logic        ack_ready;
    logic [1:0]  ack_pe = '0;
    logic [15:0] ack_data = '0;

    int n_chk  = 0;
    int n_fail = 0;

    logic [1:0]  got_kind;
    logic [15:0] got_data;
    logic [1:0]  got_pe;
    logic [3:0]  got_mask;
    logic [1:0]  got_pk;
    bit          order_ok;

    always #4 clk = ~clk;

    coh_dir_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_pe(req_pe),
        .req_op(req_op), .req_blk(req_blk), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pe(rsp_pe),
        .rsp_kind(rsp_kind), .rsp_data(rsp_data),
        .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_pe(prb_pe),
        .prb_kind(prb_kind), .prb_blk(prb_blk),
        .ack_valid(ack_valid), .ack_ready(ack_ready), .ack_pe(ack_pe),
        .ack_data(ack_data)
    );

    typedef struct packed {
        logic [3:0]  rq;   // requirement number printed in messages
        logic [1:0]  op;
        logic [1:0]  pe;
        logic [2:0]  blk;
        logic [15:0] wd;
        logic [1:0]  ek;   // expected response kind
        logic [15:0] ed;   // expected response data
        logic [3:0]  em;   // expected set of probed PEs
        logic [1:0]  epk;  // expected probe kind
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'd2, 2'd0, 2'd0, 3'd1, 16'h0000, 2'd0, 16'h0011, 4'b0000, 2'd0}, // R2 R1
        '{4'd2, 2'd0, 2'd1, 3'd1, 16'h0000, 2'd0, 16'h0011, 4'b0000, 2'd0}, // R2
        '{4'd2, 2'd0, 2'd2, 3'd1, 16'h0000, 2'd0, 16'h0011, 4'b0000, 2'd0}, // R2
        '{4'd4, 2'd1, 2'd1, 3'd1, 16'h0000, 2'd1, 16'h0011, 4'b0101, 2'd1}, // R4 R5
        '{4'd3, 2'd0, 2'd3, 3'd1, 16'h0000, 2'd0, 16'hC011, 4'b0010, 2'd0}, // R3
        '{4'd3, 2'd1, 2'd0, 3'd1, 16'h0000, 2'd1, 16'hC011, 4'b1010, 2'd1}, // R3 R4
        '{4'd6, 2'd1, 2'd2, 3'd1, 16'h0000, 2'd1, 16'hC001, 4'b0001, 2'd2}, // R6
        '{4'd8, 2'd2, 2'd2, 3'd1, 16'h1234, 2'd3, 16'h0000, 4'b0000, 2'd0}, // R8
        '{4'd8, 2'd0, 2'd3, 3'd1, 16'h0000, 2'd0, 16'h1234, 4'b0000, 2'd0}, // R8
        '{4'd8, 2'd1, 2'd0, 3'd1, 16'h0000, 2'd1, 16'h1234, 4'b1000, 2'd1}, // R8 R10
        '{4'd8, 2'd2, 2'd3, 3'd1, 16'h5555, 2'd3, 16'h0000, 4'b0000, 2'd0}, // R8
        '{4'd8, 2'd0, 2'd1, 3'd1, 16'h0000, 2'd0, 16'hC001, 4'b0001, 2'd0}, // R8 R3
        '{4'd1, 2'd0, 2'd2, 3'd5, 16'h0000, 2'd0, 16'h0055, 4'b0000, 2'd0}, // R1 R2
        '{4'd5, 2'd1, 2'd2, 3'd5, 16'h0000, 2'd1, 16'h0055, 4'b0000, 2'd0}  // R5
    };

    function automatic logic [15:0] ackd(input logic [1:0] pe, input logic [2:0] blk);
        return 16'hC000 | {8'h00, 2'b00, pe, 1'b0, blk};
    endfunction

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one request, answer every probe at once, wait for the response
    task automatic do_txn(input logic [1:0] op, input logic [1:0] pe,
                          input logic [2:0] blk, input logic [15:0] wd);
        bit done;
        int prev;
        got_mask = '0;
        got_pk   = '0;
        order_ok = 1'b1;
        prev     = -1;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_pe = pe; req_blk = blk; req_data = wd;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            req_valid = 1'b0;
            ack_valid = prb_valid;
            ack_pe    = prb_pe;
            ack_data  = ackd(prb_pe, prb_blk);
            if (prb_valid) begin
                got_mask[prb_pe] = 1'b1;
                got_pk = prb_kind;
                if (int'(prb_pe) <= prev) order_ok = 1'b0;
                prev = int'(prb_pe);
            end
            if (rsp_valid) begin
                got_kind = rsp_kind;
                got_data = rsp_data;
                got_pe   = rsp_pe;
                done     = 1'b1;
            end
        end
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state at the ports
        check_eq("R1 req_ready after reset", 32'(req_ready), 32'd1);
        check_eq("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
        check_eq("R1 prb_valid after reset", 32'(prb_valid), 32'd0);
        check_eq("R1 ack_ready after reset", 32'(ack_ready), 32'd0);

        for (int v = 0; v < NV; v++) begin
            do_txn(VEC[v].op, VEC[v].pe, VEC[v].blk, VEC[v].wd);
            check_eq($sformatf("R%0d vec%0d rsp kind", VEC[v].rq, v), 32'(got_kind), 32'(VEC[v].ek));
            check_eq($sformatf("R%0d vec%0d rsp data", VEC[v].rq, v), 32'(got_data), 32'(VEC[v].ed));
            check_eq($sformatf("R%0d vec%0d rsp pe", VEC[v].rq, v), 32'(got_pe), 32'(VEC[v].pe));
            check_eq($sformatf("R%0d/R5 vec%0d probed set", VEC[v].rq, v), 32'(got_mask), 32'(VEC[v].em));
            if (VEC[v].em != 4'b0000) begin
                check_eq($sformatf("R%0d vec%0d probe kind", VEC[v].rq, v), 32'(got_pk), 32'(VEC[v].epk));
                check_eq($sformatf("R4 vec%0d probe order", v), 32'(order_ok), 32'd1);
            end
        end

        // R7 and R9: retry response and stalled probe in the same cycle
        do_txn(2'd0, 2'd1, 3'd3, 16'h0);
        check_eq("R2 blk3 read data", 32'(got_data), 32'h33);
        @(negedge clk);
        prb_ready = 1'b0;
        req_valid = 1'b1; req_op = 2'd1; req_pe = 2'd0; req_blk = 3'd3;
        #1;
        check_eq("R4 write accepted", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R4 invalidate valid", 32'(prb_valid), 32'd1);
        check_eq("R4 invalidate target", 32'(prb_pe), 32'd1);
        check_eq("R4 invalidate kind", 32'(prb_kind), 32'd1);
        rsp_ready = 1'b0;
        req_valid = 1'b1; req_op = 2'd0; req_pe = 2'd2; req_blk = 3'd3;
        #1;
        check_eq("R7 busy block request taken", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R7 retry valid", 32'(rsp_valid), 32'd1);
        check_eq("R7 retry kind", 32'(rsp_kind), 32'd2);
        check_eq("R7 retry pe", 32'(rsp_pe), 32'd2);
        check_eq("R9 probe still valid", 32'(prb_valid), 32'd1);
        @(negedge clk);
        check_eq("R9 retry held", 32'({rsp_valid, rsp_kind, rsp_pe}), 32'({1'b1, 2'd2, 2'd2}));
        check_eq("R9 probe held", 32'({prb_valid, prb_kind, prb_pe, prb_blk}),
                 32'({1'b1, 2'd1, 2'd1, 3'd3}));
        rsp_ready = 1'b1;
        @(negedge clk);
        check_eq("R7 retry drained", 32'(rsp_valid), 32'd0);
        req_valid = 1'b1; req_op = 2'd0; req_pe = 2'd2; req_blk = 3'd4;
        #1;
        check_eq("R7 other block stalled", 32'(req_ready), 32'd0);
        req_valid = 1'b0;
        prb_ready = 1'b1;
        ack_valid = 1'b1; ack_pe = 2'd1; ack_data = 16'h0;
        @(negedge clk);
        ack_valid = 1'b0;
        for (int w = 0; w < 8 && !rsp_valid; w++) @(negedge clk);
        check_eq("R4 grant after ack kind", 32'(rsp_kind), 32'd1);
        check_eq("R4 grant after ack pe", 32'(rsp_pe), 32'd0);
        check_eq("R4 grant after ack data", 32'(rsp_data), 32'h33);
        @(negedge clk);

        // R7: retried reader was not recorded as a sharer
        do_txn(2'd2, 2'd0, 3'd3, 16'h7777);
        check_eq("R8 owner write-back done", 32'(got_kind), 32'd3);
        do_txn(2'd1, 2'd3, 3'd3, 16'h0);
        check_eq("R7 no sharer left by retry", 32'(got_mask), 32'd0);
        check_eq("R8 write-back data kept", 32'(got_data), 32'h7777);

        // R1: reset mid-run restores memory and empties the directory
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_txn(2'd1, 2'd0, 3'd3, 16'h0);
        check_eq("R1 directory cleared by reset", 32'(got_mask), 32'd0);
        check_eq("R1 memory reloaded by reset", 32'(got_data), 32'h33);

        finish_run();
    end

endmodule